// File: doc/BRIEF.md
# Low-power mode sequencing controller

This block sequences the power modes of a small processor subsystem. Starting in the running state, a wait-for-interrupt strobe from the CPU moves it either into a light idle state or, when the deep-sleep select bit is set, towards deep sleep. In idle, only the CPU clock is stopped. The route to deep sleep first passes through a holding state. The block stays in that state while a debugger asks for memory access. On leaving it, the block picks one of three depths.

The first depth is an emulated sleep that keeps core power. It is used whenever a debugger is attached. The other two remove core power. They differ in whether the low-frequency RC oscillator keeps running. In the deepest level, timer-based wake sources count only when a crystal is present. Waking from a powered-down level re-enables the oscillator and core power. The core reset is then held for a fixed number of cycles before running resumes.

Top module: `lp_seq_ctrl`

## Requirements
- R1: After reset the state code is 0 (running), with core power on, core reset low, CPU clock enabled and RC oscillator enabled. The state codes are: running 0, idle 1, pre-deep 2, emulated deep 3, deep level 1 4, deep level 2 5, wake/reset 6.
- R2: In running, a strobe on `wfi_i` with `deep_sel_i` low gives state 1 on the next cycle. Idle has the CPU clock off, core power on and reset low. `irq_i` high in idle returns to state 0 on the next cycle.
- R3: In running, a strobe on `wfi_i` with `deep_sel_i` high gives state 2. State 2 keeps core power on, reset low and the CPU clock off.
- R4: The block stays in state 2 while `dbg_sys_req_i` is high.
- R5: Leaving state 2 with `dbg_att_i` high enters state 3, which keeps core power and never asserts core reset. `irq_i`, any wake input or `dbg_sys_req_i` returns from state 3 directly to state 0.
- R6: Leaving state 2 with `dbg_att_i` low enters state 4 when `lvl2_sel_i` is low, and state 5 when it is high. Both remove core power, assert core reset and stop the CPU clock. The RC oscillator runs in state 4 and is off in state 5.
- R7: In state 5, `wake_tmr_i` has no effect unless `xtal_ok_i` is high. `wake_ext_i` wakes the block regardless of `xtal_ok_i`.
- R8: `dbg_sys_req_i` or `dbg_att_i` high in state 4 or state 5 wakes the block into state 6.
- R9: State 6 lasts exactly 8 cycles, with core power on, RC oscillator on and core reset high. It is followed by state 0, with reset low.
- R10: `wfi_i` is ignored in every state except running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the CPU |
| deep_sel_i | input | 1 | Selects deep sleep for the next strobe |
| dbg_sys_req_i | input | 1 | Debugger requests memory access |
| dbg_att_i | input | 1 | Debugger attached |
| lvl2_sel_i | input | 1 | Choose deep level 2 over level 1 |
| xtal_ok_i | input | 1 | Low-frequency crystal present |
| irq_i | input | 1 | Interrupt pending |
| wake_tmr_i | input | N_TMR | Timer-based wake sources |
| wake_ext_i | input | N_EXT | Non-timer wake sources |
| core_pwr_o | output | 1 | Core-domain power enable |
| core_rst_o | output | 1 | Core reset |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| rco_en_o | output | 1 | RC oscillator enable |
| state_o | output | 3 | Current state code |

## Verification
The hardest case to reach is deep level 2 with a timer wake while the crystal flag is low. Reaching it needs a deep-select strobe, a cleared memory request, no attached debugger and the level-2 choice all lined up. Then every other wake source must stay quiet for several cycles. A directed sequence sets up exactly that case and then releases the crystal flag. Long random runs also visit it, and a cycle-accurate bench model checks every cycle, including the length of the reset hold.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IDLE = 3'd1,
    ST_PRE  = 3'd2,
    ST_DS0  = 3'd3,
    ST_DS1  = 3'd4,
    ST_DS2  = 3'd5,
    ST_WAKE = 3'd6
  } lp_state_e;

  typedef struct packed {
    logic pwr;
    logic rst;
    logic clk_en;
    logic rco_en;
  } lp_ctrl_t;
endpackage

// File: rtl/lp_wake_qual.sv
module lp_wake_qual #(
  parameter int N_TMR = 2,
  parameter int N_EXT = 4
) (
  input  logic             irq_i,
  input  logic [N_TMR-1:0] tmr_i,
  input  logic [N_EXT-1:0] ext_i,
  input  logic             dbg_sys_i,
  input  logic             dbg_att_i,
  input  logic             xtal_ok_i,
  output logic             idle_wake_o,
  output logic             ds0_wake_o,
  output logic             ds1_wake_o,
  output logic             ds2_wake_o
);
  logic any_tmr, any_ext, any_dbg;

  always_comb begin
    any_tmr     = |tmr_i;
    any_ext     = |ext_i;
    any_dbg     = dbg_sys_i | dbg_att_i;
    idle_wake_o = irq_i;
    // core stays powered in level 0, so the rc and its timers keep working
    ds0_wake_o  = irq_i | any_tmr | any_ext | dbg_sys_i;
    ds1_wake_o  = any_tmr | any_ext | any_dbg;
    // rc is off in level 2: timers need the crystal
    ds2_wake_o  = (any_tmr & xtal_ok_i) | any_ext | any_dbg;
  end
endmodule

// File: rtl/lp_hold_cnt.sv
module lp_hold_cnt #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || done_o)      cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R9
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wfi_i,
  input  logic      deep_sel_i,
  input  logic      dbg_sys_i,
  input  logic      dbg_att_i,
  input  logic      lvl2_sel_i,
  input  logic      idle_wake_i,
  input  logic      ds0_wake_i,
  input  logic      ds1_wake_i,
  input  logic      ds2_wake_i,
  input  logic      hold_done_i,
  output lp_state_e st_o
);
  lp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (wfi_i) st_d = deep_sel_i ? ST_PRE : ST_IDLE;
      ST_IDLE: if (idle_wake_i) st_d = ST_RUN;
      ST_PRE: begin
        // depth chosen from the debugger lines at the moment of leaving
        if (!dbg_sys_i) begin
          if (dbg_att_i)       st_d = ST_DS0;
          else if (lvl2_sel_i) st_d = ST_DS2;
          else                 st_d = ST_DS1;
        end
      end
      ST_DS0:  if (ds0_wake_i) st_d = ST_RUN;
      ST_DS1:  if (ds1_wake_i) st_d = ST_WAKE;
      ST_DS2:  if (ds2_wake_i) st_d = ST_WAKE;
      ST_WAKE: if (hold_done_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE && dbg_sys_i) |=> st_q == ST_PRE); // R4
  AST_DS0_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE && !dbg_sys_i && dbg_att_i) |=> st_q == ST_DS0); // R5
  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE && !hold_done_i) |=> st_q == ST_WAKE); // R9
  AST_DS0_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DS0) |=> st_q != ST_WAKE); // R5
endmodule

// File: rtl/lp_out_dec.sv
module lp_out_dec
  import lp_seq_pkg::*;
(
  input  lp_state_e st_i,
  output lp_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{pwr: 1'b1, rst: 1'b0, clk_en: 1'b0, rco_en: 1'b1};
    unique case (st_i)
      ST_RUN:  ctrl_o.clk_en = 1'b1;
      ST_IDLE, ST_PRE, ST_DS0: ;
      ST_DS1:  begin ctrl_o.pwr = 1'b0; ctrl_o.rst = 1'b1; end
      ST_DS2:  begin ctrl_o.pwr = 1'b0; ctrl_o.rst = 1'b1; ctrl_o.rco_en = 1'b0; end
      ST_WAKE: ctrl_o.rst = 1'b1;
      default: ctrl_o.clk_en = 1'b1;
    endcase
  end
endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
  import lp_seq_pkg::*;
#(
  parameter int N_TMR    = 2,
  parameter int N_EXT    = 4,
  parameter int HOLD_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wfi_i,
  input  logic             deep_sel_i,
  input  logic             dbg_sys_req_i,
  input  logic             dbg_att_i,
  input  logic             lvl2_sel_i,
  input  logic             xtal_ok_i,
  input  logic             irq_i,
  input  logic [N_TMR-1:0] wake_tmr_i,
  input  logic [N_EXT-1:0] wake_ext_i,
  output logic             core_pwr_o,
  output logic             core_rst_o,
  output logic             cpu_clk_en_o,
  output logic             rco_en_o,
  output logic [2:0]       state_o
);
  logic      idle_wake, ds0_wake, ds1_wake, ds2_wake, hold_done;
  lp_state_e st;
  lp_ctrl_t  ctrl;

  lp_wake_qual #(.N_TMR(N_TMR), .N_EXT(N_EXT)) i_wake (
    .irq_i       (irq_i),
    .tmr_i       (wake_tmr_i),
    .ext_i       (wake_ext_i),
    .dbg_sys_i   (dbg_sys_req_i),
    .dbg_att_i   (dbg_att_i),
    .xtal_ok_i   (xtal_ok_i),
    .idle_wake_o (idle_wake),
    .ds0_wake_o  (ds0_wake),
    .ds1_wake_o  (ds1_wake),
    .ds2_wake_o  (ds2_wake)
  );

  lp_hold_cnt #(.HOLD_CYC(HOLD_CYC)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st == ST_WAKE),
    .done_o (hold_done)
  );

  lp_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_i       (wfi_i),
    .deep_sel_i  (deep_sel_i),
    .dbg_sys_i   (dbg_sys_req_i),
    .dbg_att_i   (dbg_att_i),
    .lvl2_sel_i  (lvl2_sel_i),
    .idle_wake_i (idle_wake),
    .ds0_wake_i  (ds0_wake),
    .ds1_wake_i  (ds1_wake),
    .ds2_wake_i  (ds2_wake),
    .hold_done_i (hold_done),
    .st_o        (st)
  );

  lp_out_dec i_dec (
    .st_i   (st),
    .ctrl_o (ctrl)
  );

  assign core_pwr_o   = ctrl.pwr;
  assign core_rst_o   = ctrl.rst;
  assign cpu_clk_en_o = ctrl.clk_en;
  assign rco_en_o     = ctrl.rco_en;
  assign state_o      = st;

  AST_TMR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && !xtal_ok_i && wake_ext_i == '0 && !dbg_sys_req_i && !dbg_att_i)
      |=> state_o == 3'd5); // R7
  AST_WFI_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && !irq_i) |=> state_o == 3'd1); // R10
  AST_PWR_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> core_pwr_o && state_o == 3'd0); // R9
  AST_DBG_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd4 || state_o == 3'd5) && (dbg_sys_req_i || dbg_att_i))
      |=> state_o == 3'd6); // R8
endmodule

// File: tb/test_lp_seq_ctrl.sv
module test_lp_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_TMR = 2;
  localparam int N_EXT = 4;
  localparam int HOLD  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi = 0, deep = 0, dsys = 0, datt = 0, lvl2 = 0, xtal = 0, irq = 0;
  logic [N_TMR-1:0] tmr = '0;
  logic [N_EXT-1:0] ext = '0;
  logic pwr, crst, cclk, rco;
  logic [2:0] st;

  int checks = 0, errors = 0;
  int exp_st = 0, exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_seq_ctrl #(.N_TMR(N_TMR), .N_EXT(N_EXT), .HOLD_CYC(HOLD)) i_lp_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .deep_sel_i(deep),
    .dbg_sys_req_i(dsys), .dbg_att_i(datt), .lvl2_sel_i(lvl2),
    .xtal_ok_i(xtal), .irq_i(irq), .wake_tmr_i(tmr), .wake_ext_i(ext),
    .core_pwr_o(pwr), .core_rst_o(crst), .cpu_clk_en_o(cclk),
    .rco_en_o(rco), .state_o(st)
  );

  function automatic int f_next(int s, int cnt);
    logic t, e;
    t = |tmr; e = |ext;
    case (s)
      0: return wfi ? (deep ? 2 : 1) : 0;
      1: return irq ? 0 : 1;
      2: return dsys ? 2 : (datt ? 3 : (lvl2 ? 5 : 4));
      3: return (irq | t | e | dsys) ? 0 : 3;
      4: return (t | e | dsys | datt) ? 6 : 4;
      5: return ((t & xtal) | e | dsys | datt) ? 6 : 5;
      6: return (cnt == HOLD-1) ? 0 : 6;
      default: return 0;
    endcase
  endfunction

  // {pwr, rst, clk_en, rco_en}
  function automatic logic [3:0] f_ctrl(int s);
    case (s)
      0: return 4'b1011;
      1, 2, 3: return 4'b1001;
      4: return 4'b0101;
      5: return 4'b0100;
      6: return 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string f_tag(int s);
    case (s)
      0: return "R1";  1: return "R2";  2: return "R4";  3: return "R5";
      4, 5: return "R6";  6: return "R9";  default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin exp_st <= 0; exp_cnt <= 0; end
    else begin
      exp_st  <= f_next(exp_st, exp_cnt);
      exp_cnt <= (exp_st == 6 && exp_cnt != HOLD-1) ? exp_cnt + 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(f_tag(exp_st), int'(st), exp_st);
    chk(f_tag(exp_st), int'({pwr, crst, cclk, rco}), int'(f_ctrl(exp_st)));
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    cmp_model();
  endtask

  task automatic quiet();
    wfi = 0; irq = 0; tmr = '0; ext = '0; dsys = 0; datt = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int wlen;
    int seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", int'(st), 0);
    chk("R1", int'({pwr, crst, cclk, rco}), 11);

    // R2 idle entry, R10 strobe ignored, irq exit
    wfi = 1; deep = 0; cyc(); wfi = 0;
    chk("R2", int'(st), 1);
    chk("R2", int'(cclk), 0);
    wfi = 1; deep = 1; cyc(); wfi = 0;
    chk("R10", int'(st), 1);
    irq = 1; cyc(); irq = 0;
    chk("R2", int'(st), 0);

    // R3/R4 pre-deep hold under memory request
    wfi = 1; deep = 1; dsys = 1; cyc(); wfi = 0;
    chk("R3", int'(st), 2);
    repeat (3) cyc();
    chk("R4", int'(st), 2);
    chk("R3", int'(pwr), 1);

    // R5 emulated level 0, wake without reset
    dsys = 0; datt = 1; cyc();
    chk("R5", int'(st), 3);
    chk("R5", int'(crst), 0);
    ext = 4'b0100; cyc(); quiet();
    chk("R5", int'(st), 0);

    // R6/R7 level 2 timer masking, then R9 hold length
    lvl2 = 1; xtal = 0;
    wfi = 1; deep = 1; cyc(); wfi = 0; cyc();
    chk("R6", int'(st), 5);
    chk("R6", int'(rco), 0);
    tmr = 2'b10; cyc(); cyc();
    chk("R7", int'(st), 5);
    xtal = 1; cyc(); tmr = '0; xtal = 0;
    chk("R7", int'(st), 6);
    wlen = 1;
    while (st == 3'd6 && wlen < 20) begin
      chk("R9", int'(crst & pwr & rco), 1);
      cyc(); wlen++;
    end
    chk("R9", wlen - 1, HOLD);
    chk("R9", int'(st), 0);

    // R6 level 1 and R8 debugger wake
    lvl2 = 0; wfi = 1; deep = 1; cyc(); wfi = 0; cyc();
    chk("R6", int'(st), 4);
    chk("R6", int'(rco), 1);
    datt = 1; cyc(); datt = 0;
    chk("R8", int'(st), 6);
    repeat (HOLD) cyc();

    // random stimulus against the model
    for (int i = 0; i < 6000; i++) begin
      wfi  = ($urandom % 100) < 15;
      deep = ($urandom % 100) < 60;
      dsys = ($urandom % 100) < 20;
      datt = ($urandom % 100) < 25;
      lvl2 = $urandom % 2;
      xtal = $urandom % 2;
      irq  = ($urandom % 100) < 10;
      for (int b = 0; b < N_TMR; b++) tmr[b] = ($urandom % 100) < 5;
      for (int b = 0; b < N_EXT; b++) ext[b] = ($urandom % 100) < 3;
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule